// File: doc/BRIEF.md
# Streamed Multi-Axis Step Pulse Sequencer

This block turns a stream of 32-bit command words into step and direction levels for six motor axes. A producer such as a FIFO that a DMA engine keeps topped up presents each word on a valid/ready port. The block takes one word at a time and runs it to completion with no processor help. Each word sets the direction levels, waits a programmed number of timer ticks, then raises the step lines it selects for a programmed number of ticks.

All timing counts a shared tick strobe (`tick_i`), which is one clock wide and sets the motion time base. The command stream needs no alignment to that tick. Four flag bits in each word give one-clock event strobes at the step edge. Software uses them to act at exact points in the stream. A hold input stops new words being taken, for feed hold, but a word already running always finishes. An idle output shows when the queue has run dry.

Command word fields:

- bits[5:0] are the step mask (bit n = axis n).
- bits[11:6] are the direction levels (bit 6+n = axis n).
- bits[19:12] are the pre-step delay in ticks.
- bits[27:20] are the step width in ticks.
- bits[31:28] are the event flags (bit 28+k = `evt_o[k]`).

Top module: `stepgen_stream`

## Requirements
- R1: `dir_o[n]` takes bit 6+n of a word in the clock cycle after the word is accepted (`cmd_valid_i` and `cmd_ready_o` both high at a clock edge). It does not change at any other time.
- R2: After acceptance the block counts ticks. A tick is counted when `tick_i` is high at a clock edge after the accept edge. On the edge that counts the delay-th tick (delay = bits[19:12]), `step_o` becomes bits[5:0] exactly. Until then `step_o` is zero.
- R3: A delay field of 0 behaves as a delay of 1 tick.
- R4: `step_o` holds the mask until the edge that counts the width-th further tick (width = bits[27:20]). It goes to zero at that edge. A width field of 0 behaves as 1.
- R5: `cmd_ready_o` is low from the accept edge until the word finishes. A word finishes when the step lines return to zero, or at the end of the delay for a zero mask. At all other times it is high, except when pause holds it low.
- R6: On the edge where the step lines rise, `evt_o[k]` goes high for exactly one clock for each set bit 28+k. At every other time `evt_o` is zero.
- R7: A word with an all-zero mask produces no step activity. Its flag strobes fire on the edge that ends its delay, and the word finishes on that same edge.
- R8: While `pause_i` is high and no word is running, `cmd_ready_o` is low and no word is taken. Pause raised while a word runs does not shorten its delay or its pulse.
- R9: `idle_o` is high exactly when no word is running and `cmd_valid_i` is low.
- R10: After reset, `step_o`, `dir_o` and `evt_o` are zero, `cmd_ready_o` is high and no word is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Step time base strobe, one clock wide |
| pause_i | input | 1 | Feed hold: block new words |
| cmd_valid_i | input | 1 | Command word valid |
| cmd_data_i | input | 32 | Command word |
| cmd_ready_o | output | 1 | Block can take a word |
| step_o | output | 6 | Step lines, one per axis |
| dir_o | output | 6 | Direction lines, one per axis |
| evt_o | output | 4 | Event strobes from the word flags |
| idle_o | output | 1 | No word running and none offered |

## Verification
The embedded assertions check these rules on every cycle:

- Direction changes only on an accept edge.
- Step edges, rising or falling, happen only on edges where a tick was sampled.
- The mask stays steady while high, and no word is taken during a pulse.
- Event strobes last one clock and fall on a rising step edge or on a zero-mask finish.
- Idle implies quiet step lines.

The bench scenarios show the exact tick counts for delay and width, including the zero-to-one clamps and the 255 limits, and the zero-mask path. They also show that pause raised mid-word leaves timing intact. These depend on whole command sequences under varied tick rates and input gaps.

// File: rtl/stepgen_pkg.sv
package stepgen_pkg;
  localparam int unsigned AXES   = 6;
  localparam int unsigned CNT_W  = 8;
  localparam int unsigned FLAG_W = 4;
  localparam int unsigned WORD_W = 2*AXES + 2*CNT_W + FLAG_W;

  // packed MSB first: flags | width | delay | dir | mask
  typedef struct packed {
    logic [FLAG_W-1:0] flags;
    logic [CNT_W-1:0]  width;
    logic [CNT_W-1:0]  delay;
    logic [AXES-1:0]   dir;
    logic [AXES-1:0]   mask;
  } cmd_t;

  typedef enum logic [1:0] {ST_IDLE, ST_DELAY, ST_PULSE} seq_state_e;
endpackage

// File: rtl/stepgen_unpack.sv
module stepgen_unpack
  import stepgen_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output cmd_t              cmd_o
);
  cmd_t raw;
  assign raw = cmd_t'(word_i);

  // zero counts clamp to one tick so setup and width are never zero
  always_comb begin
    cmd_o = raw;
    if (raw.delay == '0) cmd_o.delay = CNT_W'(1);
    if (raw.width == '0) cmd_o.width = CNT_W'(1);
  end

  always_comb begin
    a_r3_delay_nonzero: assert (cmd_o.delay != '0);
    a_r4_width_nonzero: assert (cmd_o.width != '0);
  end
endmodule

// File: rtl/stepgen_seq.sv
module stepgen_seq
  import stepgen_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              pause_i,
  input  logic              valid_i,
  input  cmd_t              cmd_i,
  output logic              ready_o,
  output logic              busy_o,
  output logic [AXES-1:0]   step_o,
  output logic [AXES-1:0]   dir_o,
  output logic              fire_o,
  output logic [FLAG_W-1:0] flags_o
);
  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q, width_q;
  logic [AXES-1:0]  mask_q;
  logic             last_tick;

  assign ready_o   = (state_q == ST_IDLE) && !pause_i;
  assign busy_o    = (state_q != ST_IDLE);
  assign last_tick = tick_i && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      width_q <= '0;
      mask_q  <= '0;
      dir_o   <= '0;
      step_o  <= '0;
      flags_o <= '0;
      fire_o  <= 1'b0;
    end else begin
      fire_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (valid_i && ready_o) begin
          dir_o   <= cmd_i.dir;
          mask_q  <= cmd_i.mask;
          flags_o <= cmd_i.flags;
          cnt_q   <= cmd_i.delay;
          width_q <= cmd_i.width;
          state_q <= ST_DELAY;
        end
        ST_DELAY: if (last_tick) begin
          fire_o <= 1'b1;
          if (mask_q != '0) begin
            step_o  <= mask_q;
            cnt_q   <= width_q;
            state_q <= ST_PULSE;
          end else begin
            state_q <= ST_IDLE;
          end
        end else if (tick_i) begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
        ST_PULSE: if (last_tick) begin
          step_o  <= '0;
          state_q <= ST_IDLE;
        end else if (tick_i) begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r1_dir_only_on_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dir_o) |-> $past(valid_i && ready_o));
  a_r2_rise_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(|step_o) |-> $past(tick_i));
  a_r4_fall_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(|step_o) |-> $past(tick_i));
  a_r2_mask_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|step_o) && (|$past(step_o))) |-> (step_o == $past(step_o)));
endmodule

// File: rtl/stepgen_evt.sv
module stepgen_evt
  import stepgen_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic [FLAG_W-1:0] evt_o
);
  for (genvar k = 0; k < FLAG_W; k++) begin : g_evt
    assign evt_o[k] = fire_i & flags_i[k];
  end

  a_r6_one_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_o) |=> (evt_o == '0));
endmodule

// File: rtl/stepgen_stream.sv
module stepgen_stream
  import stepgen_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              pause_i,
  input  logic              cmd_valid_i,
  input  logic [WORD_W-1:0] cmd_data_i,
  output logic              cmd_ready_o,
  output logic [AXES-1:0]   step_o,
  output logic [AXES-1:0]   dir_o,
  output logic [FLAG_W-1:0] evt_o,
  output logic              idle_o
);
  cmd_t              cmd;
  logic              busy, fire;
  logic [FLAG_W-1:0] flags;

  stepgen_unpack u_unpack (.word_i(cmd_data_i), .cmd_o(cmd));

  stepgen_seq u_seq (
    .clk_i, .rst_ni, .tick_i, .pause_i,
    .valid_i(cmd_valid_i), .cmd_i(cmd),
    .ready_o(cmd_ready_o), .busy_o(busy),
    .step_o, .dir_o, .fire_o(fire), .flags_o(flags)
  );

  stepgen_evt u_evt (.clk_i, .rst_ni, .fire_i(fire), .flags_i(flags), .evt_o);

  assign idle_o = !busy && !cmd_valid_i;

  a_r5_no_take_in_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|step_o) |-> !cmd_ready_o);
  a_r6_evt_at_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_o) |-> ($rose(|step_o) || (step_o == '0)));
  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> (step_o == '0));
  a_r8_pause_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_i |-> !cmd_ready_o);
endmodule

// File: tb/sim_stepgen_stream.sv
module sim_stepgen_stream;
  localparam int N = 48;
  localparam int LIMIT = 150000;

  logic clk = 1'b0, rst_ni = 1'b0, tick_i = 1'b0, pause_i = 1'b0, cmd_valid_i = 1'b0;
  logic [31:0] cmd_data_i = '0;
  logic cmd_ready_o, idle_o;
  logic [5:0] step_o, dir_o;
  logic [3:0] evt_o;

  always #2 clk = ~clk;

  stepgen_stream u0 (.clk_i(clk), .rst_ni, .tick_i, .pause_i, .cmd_valid_i, .cmd_data_i,
                     .cmd_ready_o, .step_o, .dir_o, .evt_o, .idle_o);

  int checks = 0, fails = 0;
  logic [31:0] words [N];

  function automatic logic [31:0] mk(int fl, int w, int d, int dr, int m);
    return {fl[3:0], w[7:0], d[7:0], dr[5:0], m[5:0]};
  endfunction
  function automatic int clamp1(logic [7:0] v);
    return (v == 8'd0) ? 1 : int'(v);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  initial begin
    int idx = 0, done = 0, cyc = 0, dcnt = 0, wcnt = 0, e_d = 1, e_w = 1;
    bit busy = 0, in_delay = 0, in_pulse = 0, rise_due = 0, fall_due = 0, acc_last = 0;
    logic [5:0] e_mask = '0, e_dir = '0;
    logic [3:0] e_fl = '0;
    void'($urandom(32'd1234));
    words[0] = mk(0, 0, 0, 'h2A, 'h3F);     // R3 R4 clamps
    words[1] = mk(1, 3, 5, 'h3F, 'h01);
    words[2] = mk('hA, 9, 4, 'h15, 'h00);   // R7 zero mask
    words[3] = mk('hF, 1, 255, 'h00, 'h20);
    words[4] = mk(0, 255, 1, 'h11, 'h12);
    words[5] = mk(0, 7, 2, 'h3F, 'h00);     // R7 zero mask, no flags
    words[6] = mk(8, 0, 0, 'h01, 'h3F);
    words[7] = mk(2, 2, 3, 'h20, 'h0C);
    for (int i = 8; i < N; i++)
      words[i] = mk($urandom % 16, $urandom % 24, $urandom % 24, $urandom % 64,
                    ($urandom % 5 == 0) ? 0 : $urandom % 64);

    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    #1;
    // R10 reset state
    chk(step_o == 0, "R10 step", step_o, 0);
    chk(dir_o == 0, "R10 dir", dir_o, 0);
    chk(evt_o == 0, "R10 evt", evt_o, 0);
    chk(cmd_ready_o == 1, "R10 ready", cmd_ready_o, 1);
    chk(idle_o == 1, "R10 idle", idle_o, 1);

    while ((done < N) && (cyc < LIMIT)) begin
      @(posedge clk); #1;
      cyc++;
      // drive
      if (acc_last) begin cmd_valid_i = 0; acc_last = 0; end
      if (!cmd_valid_i && idx < N && ($urandom % 4 != 0)) begin
        cmd_valid_i = 1; cmd_data_i = words[idx];
      end
      if (idx >= 8 && idx < 12) pause_i = busy ? 1'b1 : 1'($urandom % 2);  // R8 mid-word pause
      else pause_i = ($urandom % 10 == 0);
      if (idx < 16) tick_i = 1'b1;
      else if (idx < 32) tick_i = 1'($urandom % 2);
      else tick_i = (cyc % 3 == 0);
      #1;
      // monitor
      chk(dir_o == e_dir, "R1 dir", dir_o, e_dir);
      if (rise_due) begin
        rise_due = 0; in_delay = 0;
        chk(step_o == e_mask, "R2 step rise", step_o, e_mask);
        chk(evt_o == e_fl, e_mask == 0 ? "R7 evt at delay end" : "R6 evt at rise", evt_o, e_fl);
        if (e_mask != 0) begin in_pulse = 1; wcnt = 0; end
        else begin busy = 0; done++; end
      end else if (fall_due) begin
        fall_due = 0; in_pulse = 0; busy = 0; done++;
        chk(step_o == 0, "R4 step fall", step_o, 0);
        chk(evt_o == 0, "R6 evt quiet", evt_o, 0);
      end else begin
        if (in_pulse) chk(step_o == e_mask, "R4 step held", step_o, e_mask);
        else chk(step_o == 0, "R2 step low", step_o, 0);
        chk(evt_o == 0, "R6 evt quiet", evt_o, 0);
      end
      chk(cmd_ready_o == (!busy && !pause_i), pause_i ? "R8 ready" : "R5 ready",
          cmd_ready_o, (!busy && !pause_i));
      chk(idle_o == (!busy && !cmd_valid_i), "R9 idle", idle_o, (!busy && !cmd_valid_i));
      if (cmd_valid_i && cmd_ready_o) begin
        e_mask = cmd_data_i[5:0]; e_dir = cmd_data_i[11:6];
        e_d = clamp1(cmd_data_i[19:12]); e_w = clamp1(cmd_data_i[27:20]);
        e_fl = cmd_data_i[31:28];
        busy = 1; in_delay = 1; dcnt = 0; idx++; acc_last = 1;
      end else begin
        if (in_delay && tick_i) begin dcnt++; if (dcnt == e_d) rise_due = 1; end
        if (in_pulse && tick_i) begin wcnt++; if (wcnt == e_w) fall_due = 1; end
      end
    end
    if (cyc >= LIMIT) chk(0, "watchdog", done, N);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule